// File: doc/BRIEF.md
# Packed Lane Shifter with Shuffle and Byte Align

This unit takes a 64-bit operand and applies one of several lane-wise bit movements to it. It can shift left or right, logically or arithmetically, or rotate right, on four 16-bit lanes, two 32-bit lanes or one 64-bit lane. The count comes from a scalar input. Every lane is handled on its own, so no bit ever crosses a lane boundary. The unit also offers two other operations. A halfword shuffle uses an 8-bit selector to choose, for each destination halfword, any of the four source halfwords. A byte align extracts 64 bits from the 128-bit pair formed by a second operand above the first.

Each operation is issued with a one-cycle valid strobe, and the result is registered. Alongside the result the unit produces a flag word with a negative and a zero bit for each destination lane. The position of these bits depends on lane width, and the word follows the layout a SIMD status register expects. Shifts, rotates and shuffles rebuild the flag word. Byte align leaves it untouched.

Top module: `psimd_shift`

## Requirements
- R1: `valid_out` is high in the cycle after each cycle with `valid_in` high and low otherwise; `result` and `flags` change only on a cycle with `valid_in` high.
- R2: Operation codes are 0 shift left logical, 1 shift right logical, 2 shift right arithmetic, 3 rotate right, 4 halfword shuffle, 5 byte align (6 and 7 behave as 5); lane size codes are 0 for 16-bit, 1 for 32-bit, 2 for 64-bit, and every lane shifts independently with no bits crossing into a neighbour.
- R3: Arithmetic right shift fills each lane from that lane's own sign bit; a count equal to or above the lane width gives a lane of all sign bits.
- R4: A logical shift whose count is equal to or above the lane width gives a zero lane.
- R5: Rotate right uses the count modulo the lane width, keeps all bits inside the lane, and a count that is zero modulo the width returns the lane unchanged.
- R6: Halfword shuffle: destination halfword i (bits 16i+15..16i) takes source halfword number `ctrl[2i+1:2i]`.
- R7: Byte align returns bits 63..0 of `{b, a}` shifted right by 8 times `count[2:0]`; an offset of 0 returns `a`, and higher count bits are ignored.
- R8: After a shift, rotate or shuffle, the flag word holds N = lane MSB and Z = lane all-zero: 16-bit lane h at bits 8h+7 / 8h+6, 32-bit lane w at bits 16w+15 / 16w+14, 64-bit lane at bits 31 / 30; every other bit is zero (shuffle uses the 16-bit layout).
- R9: Byte align leaves the flag word at its previous value.
- R10: Reset clears `result`, `flags` and `valid_out` to zero.
- R11: Lane size code 3 acts as the 64-bit size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Issue strobe for one operation |
| op | input | 3 | Operation code (R2) |
| size | input | 2 | Lane size code (R2, R11) |
| count | input | CNT_W | Shift/rotate count; low 3 bits are the align offset |
| ctrl | input | 8 | Shuffle selector, 2 bits per destination halfword |
| a | input | 64 | Main operand, low half of the align pair |
| b | input | 64 | High half of the align pair |
| valid_out | output | 1 | Result valid, one cycle after issue |
| result | output | 64 | Registered result |
| flags | output | 64 | Registered per-lane N/Z flag word |

## Verification
The bench uses the default count width of 8 bits. This lets a single count go past every lane width: 16, 20, 32, 63 and 64 all appear. That is enough to reach the saturating-count cases of the logical and arithmetic shifts and the modulo wrap of the rotate in all three lane sizes. The same 8-bit count carries align offsets whose upper bits are set, which shows that only the low three bits choose the byte offset.

// File: rtl/psimd_shift.sv
module psimd_shift #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [2:0]       op,
  input  logic [1:0]       size,
  input  logic [CNT_W-1:0] count,
  input  logic [7:0]       ctrl,
  input  logic [63:0]      a,
  input  logic [63:0]      b,
  output logic             valid_out,
  output logic [63:0]      result,
  output logic [63:0]      flags
);

  function automatic logic [63:0] lane_op(input logic [63:0] x, input logic [1:0] kind,
                                          input int w, input logic [CNT_W-1:0] c);
    logic [63:0] mask, ext, r;
    logic sgn, big;
    int n;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    sgn  = x[w-1];
    ext  = sgn ? (x | ~mask) : x;
    big  = (int'(c) >= w);
    n    = int'(c) % w;
    case (kind)
      2'd0:    r = big ? '0 : ((x << c) & mask);
      2'd1:    r = big ? '0 : (x >> c);
      2'd2:    r = big ? (sgn ? mask : '0) : ($unsigned($signed(ext) >>> c) & mask);
      default: r = ((x >> n) | (x << (w - n))) & mask;
    endcase
    return r;
  endfunction

  function automatic logic [63:0] nz_word(input logic [63:0] r, input logic [1:0] mode);
    logic [63:0] f;
    f = '0;
    if (mode == 2'd0) begin
      for (int h = 0; h < 4; h++) begin
        f[8*h+7] = r[16*h+15];
        f[8*h+6] = (r[16*h +: 16] == 16'd0);
      end
    end else if (mode == 2'd1) begin
      for (int w = 0; w < 2; w++) begin
        f[16*w+15] = r[32*w+31];
        f[16*w+14] = (r[32*w +: 32] == 32'd0);
      end
    end else begin
      f[31] = r[63];
      f[30] = (r == 64'd0);
    end
    return f;
  endfunction

  logic [63:0]  res_c, flg_c, tmp;
  logic [127:0] pair_sh;
  logic         upd_flags;

  always_comb begin
    res_c     = a;
    flg_c     = '0;
    upd_flags = 1'b1;
    tmp       = '0;
    pair_sh   = '0;
    if (op[2] == 1'b0) begin
      if (size == 2'd0) begin
        for (int i = 0; i < 4; i++) begin
          tmp = lane_op({48'd0, a[16*i +: 16]}, op[1:0], 16, count);
          res_c[16*i +: 16] = tmp[15:0];
        end
        flg_c = nz_word(res_c, 2'd0);
      end else if (size == 2'd1) begin
        for (int i = 0; i < 2; i++) begin
          tmp = lane_op({32'd0, a[32*i +: 32]}, op[1:0], 32, count);
          res_c[32*i +: 32] = tmp[31:0];
        end
        flg_c = nz_word(res_c, 2'd1);
      end else begin
        res_c = lane_op(a, op[1:0], 64, count);
        flg_c = nz_word(res_c, 2'd2);
      end
    end else if (op == 3'd4) begin
      for (int i = 0; i < 4; i++)
        res_c[16*i +: 16] = a[16*ctrl[2*i +: 2] +: 16];
      flg_c = nz_word(res_c, 2'd0);
    end else begin
      pair_sh   = {b, a} >> {count[2:0], 3'b000};
      res_c     = pair_sh[63:0];
      upd_flags = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      result    <= '0;
      flags     <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result <= res_c;
        if (upd_flags) flags <= flg_c;
      end
    end
  end

endmodule

// File: rtl/psimd_shift_chk.sv
module psimd_shift_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_in,
  input logic [2:0]       op,
  input logic [1:0]       size,
  input logic [CNT_W-1:0] count,
  input logic             valid_out,
  input logic [63:0]      result,
  input logic [63:0]      flags
);

  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (valid_out == $past(valid_in)));

  a_r1_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(valid_in)) |-> ($stable(result) && $stable(flags)));

  a_r8_flag_positions: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~64'h00000000C0C0C0C0) == 64'd0);

  a_r9_align_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(valid_in && (op == 3'd5 || op[2:1] == 2'b11))) |-> $stable(flags));

  a_r4_logical_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(valid_in && op[2:1] == 2'b00 && size == 2'd0 && count >= 16))
      |-> (result == 64'd0));

endmodule

bind psimd_shift psimd_shift_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .size(size),
  .count(count), .valid_out(valid_out), .result(result), .flags(flags)
);

// File: tb/psimd_shift_tb.sv
`timescale 1ns/1ps
module psimd_shift_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [7:0]  count = '0;
  logic [7:0]  ctrl = '0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        valid_out;
  logic [63:0] result, flags;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  psimd_shift #(.CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .size(size),
    .count(count), .ctrl(ctrl), .a(a), .b(b),
    .valid_out(valid_out), .result(result), .flags(flags)
  );

  localparam int NV = 20;
  localparam logic [63:0] PA = 64'h8001_4000_00FF_0000;
  localparam logic [63:0] PW = 64'h8000_0001_0000_0010;
  localparam logic [63:0] PL = 64'h0706_0504_0302_0100;
  localparam logic [63:0] PH = 64'h0F0E_0D0C_0B0A_0908;
  // {op, size, count, ctrl, a, b, expected result, expected flags}
  localparam logic [276:0] VEC [NV] = '{
    {3'd0, 2'd0, 8'd1,  8'h00, PA, 64'd0, 64'h0002_8000_01FE_0000, 64'h0000_0000_0080_0040},
    {3'd1, 2'd0, 8'd4,  8'h00, PA, 64'd0, 64'h0800_0400_000F_0000, 64'h0000_0000_0000_0040},
    {3'd2, 2'd0, 8'd4,  8'h00, PA, 64'd0, 64'hF800_0400_000F_0000, 64'h0000_0000_8000_0040},
    {3'd2, 2'd0, 8'd20, 8'h00, PA, 64'd0, 64'hFFFF_0000_0000_0000, 64'h0000_0000_8040_4040},
    {3'd0, 2'd0, 8'd16, 8'h00, PA, 64'd0, 64'h0000_0000_0000_0000, 64'h0000_0000_4040_4040},
    {3'd3, 2'd0, 8'd4,  8'h00, PA, 64'd0, 64'h1800_0400_F00F_0000, 64'h0000_0000_0000_8040},
    {3'd3, 2'd0, 8'd20, 8'h00, PA, 64'd0, 64'h1800_0400_F00F_0000, 64'h0000_0000_0000_8040},
    {3'd3, 2'd0, 8'd0,  8'h00, PA, 64'd0, PA,                      64'h0000_0000_8000_0040},
    {3'd2, 2'd1, 8'd1,  8'h00, PW, 64'd0, 64'hC000_0000_0000_0008, 64'h0000_0000_8000_0000},
    {3'd1, 2'd1, 8'd32, 8'h00, PW, 64'd0, 64'h0000_0000_0000_0000, 64'h0000_0000_4000_4000},
    {3'd3, 2'd1, 8'd4,  8'h00, PW, 64'd0, 64'h1800_0000_0000_0001, 64'h0000_0000_0000_0000},
    {3'd0, 2'd2, 8'd4,  8'h00, PW, 64'd0, 64'h0000_0010_0000_0100, 64'h0000_0000_0000_0000},
    {3'd2, 2'd2, 8'd63, 8'h00, PW, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000},
    {3'd1, 2'd2, 8'd64, 8'h00, PW, 64'd0, 64'h0000_0000_0000_0000, 64'h0000_0000_4000_0000},
    {3'd3, 2'd2, 8'd8,  8'h00, PW, 64'd0, 64'h1080_0000_0100_0000, 64'h0000_0000_0000_0000},
    {3'd4, 2'd0, 8'd0,  8'h1B, 64'h4444_3333_2222_1111, 64'd0, 64'h1111_2222_3333_4444, 64'h0},
    {3'd4, 2'd0, 8'd0,  8'h00, 64'h0000_0000_0000_8000, 64'd0, 64'h8000_8000_8000_8000, 64'h0000_0000_8080_8080},
    {3'd5, 2'd0, 8'd3,  8'h00, PL, PH, 64'h0A09_0807_0605_0403, 64'h0000_0000_8080_8080},
    {3'd5, 2'd0, 8'd0,  8'h00, PL, PH, PL,                      64'h0000_0000_8080_8080},
    {3'd5, 2'd0, 8'hFF, 8'h00, PL, PH, 64'h0E0D_0C0B_0A09_0807, 64'h0000_0000_8080_8080}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [1:0] s, input logic [7:0] c,
                       input logic [7:0] k, input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    op = o; size = s; count = c; ctrl = k; a = x; b = y; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 result after reset", result, 64'd0);
    check("R10 flags after reset", flags, 64'd0);
    check("R10 valid_out after reset", {63'd0, valid_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [276:0] v;
      v = VEC[i];
      issue(v[276:274], v[273:272], v[271:264], v[263:256], v[255:192], v[191:128]);
      // rows 0-7 R2/R3/R4/R5, 8-14 word and 64-bit lanes, 15-16 R6, 17-19 R7/R9
      check($sformatf("R2-vector %0d result (R3 R4 R5 R6 R7)", i), result, v[127:64]);
      check($sformatf("R8 vector %0d flags (R9 on align rows)", i), flags, v[63:0]);
      check("R1 valid_out after issue", {63'd0, valid_out}, 64'd1);
    end

    // R1: idle cycle with changed inputs leaves outputs and drops valid_out
    @(negedge clk);
    op = 3'd0; size = 2'd0; count = 8'd3; a = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    check("R1 result held while idle", result, 64'h0E0D_0C0B_0A09_0807);
    check("R1 flags held while idle", flags, 64'h0000_0000_8080_8080);
    check("R1 valid_out low while idle", {63'd0, valid_out}, 64'd0);

    // R11: size code 3 acts as 64-bit lane
    issue(3'd1, 2'd3, 8'd4, 8'h00, PW, 64'd0);
    check("R11 size 3 result", result, 64'h0800_0000_1000_0001);
    check("R11 size 3 flags", flags, 64'd0);

    // R9: align after a zero-flag shift keeps that flag word
    issue(3'd0, 2'd1, 8'd40, 8'h00, PW, 64'd0);
    check("R4 word overflow result", result, 64'd0);
    issue(3'd6, 2'd0, 8'd1, 8'h00, PL, PH);
    check("R7 code 6 as align", result, 64'h0807_0605_0403_0201);
    check("R9 flags kept by align", flags, 64'h0000_0000_4000_4000);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule